// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Control Front End

This block is the digital control front end of a 12-bit successive-approximation converter. Five asynchronous control lines come from a host bus: an active-high enable, an active-low select, a read/convert line, a byte address line and a word/byte mode line. The block samples them on a fast system clock and works out when a conversion must begin. It then sends a one-cycle start pulse and a conversion-length flag to a separate approximation engine, and shows a busy flag for as long as that conversion runs. When the engine reports completion, the block stores the result. It later presents the result on a modelled three-state bus, either as one 12-bit word or as two 8-bit bytes.

A conversion begins when enable is high, select is low and read/convert is low. The input that reaches its active level last is the one that triggers it. Only the byte address line is captured at that moment, and it sets the conversion length. Start requests that arrive while busy is high do not disturb the running conversion, but they do capture the byte address line again. For stand-alone use, select and byte address are tied low and enable and mode are tied high. A falling read/convert line then starts a conversion, and the result appears whenever that line is high and the block is not busy. The three-state bus is modelled as a data vector plus a per-bit output-enable vector. All timing is counted in system-clock cycles.

Top module: `sar_bus_ctrl`

## Requirements
- R1: Each time the condition (enable high, select low, read/convert low) becomes true, exactly one `conv_start` pulse of one cycle is issued, and `busy` rises in the same cycle. Any order of arrival counts, including all three inputs changing at once. Holding only two of the three conditions starts nothing.
- R2: At a start, the byte address line is captured and driven on `conv_short`: 0 selects a 12-bit conversion and 1 selects an 8-bit conversion.
- R3: `busy` stays high from the start until the cycle after `sar_done` is seen high, and is low at all other times.
- R4: While `busy` is high, a new start condition produces no `conv_start` pulse and does not extend the conversion, but it does capture the byte address line again into `conv_short`.
- R5: `dbus_oe` is all zeros, and `dbus` is zero on every undriven bit, unless read/convert is high, enable is high, select is low and `busy` is low, all together. It also stays all zeros until a conversion has completed after reset.
- R6: In a read with the mode line at 1, `dbus_oe` is all ones and `dbus` carries the whole stored result.
- R7: In a read with the mode line at 0 and the byte address at 0, `dbus_oe` has ones on bits 11..4 only, and `dbus[11:4]` carries result bits 11..4.
- R8: In a read with the mode line at 0 and the byte address at 1, `dbus_oe` has ones on bits 11..4 only. `dbus[11:8]` carries result bits 3..0 and `dbus[7:4]` is zero.
- R9: After an 8-bit conversion, the stored result keeps bits 11..4 from the engine, and bits 3..0 read back as binary 1000 whatever the engine supplied.
- R10: In the stand-alone tie-off, a falling read/convert starts a conversion, and the full result is driven while read/convert is high and `busy` is low.
- R11: During and directly after reset, `busy`, `conv_start`, `conv_short`, `dbus_oe` and `dbus` are all zero.
- R12: If a start condition and `sar_done` fall in the same cycle while busy, the conversion ends and no new one starts. The result is stored with the length captured before that cycle.
- R13: A start condition that is already present when reset is released does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Enable, active high, asynchronous |
| cs_n_in | input | 1 | Select, active low, asynchronous |
| rc_in | input | 1 | Read (1) / convert (0), asynchronous |
| a0_in | input | 1 | Byte address / conversion length, asynchronous |
| word_in | input | 1 | 1: whole-word read, 0: byte read, asynchronous |
| sar_done | input | 1 | Completion pulse from the approximation engine |
| sar_result | input | 12 | Result from the approximation engine, valid with `sar_done` |
| conv_start | output | 1 | One-cycle start pulse to the engine |
| conv_short | output | 1 | Captured length: 1 selects an 8-bit conversion |
| busy | output | 1 | High while a conversion is running |
| dbus | output | 12 | Data bus value |
| dbus_oe | output | 12 | Per-bit output enable of the data bus |

## Verification
The critical overlap is a fresh start condition that lands in the same cycle as the engine's completion pulse. The bench provokes it by dropping read/convert while busy, and changing the byte address at the same moment. It counts the input's path through the synchronizer and raises `sar_done` for exactly the clock edge where the start edge is seen. It then judges three things. No extra start pulse may appear and `busy` must fall. `conv_short` must show the newly captured address. A whole-word read must return the engine value untouched by the 8-bit marker, which shows that the ending conversion kept its old length.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

  // Synchronized view of the five host control lines.
  typedef struct packed {
    logic ce;     // enable, active high
    logic cs_n;   // select, active low
    logic rc;     // 1 = read, 0 = convert
    logic a0;     // byte address / length
    logic word;   // 1 = whole word read
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q_r;
    logic [W-1:0] q_d;

    if (s == 0) begin : g_first
      always_comb q_d = d;
    end else begin : g_next
      always_comb q_d = g_stage[s-1].q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_d;
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/sbc_trigger.sv
module sbc_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic cs_n,
  input  logic rc,
  output logic start_evt
);

  // Events stay masked until the synchronizer holds real samples.
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);
  localparam logic [CW-1:0] WARM_V = CW'(WARM);

  logic          cond;
  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed;

  always_comb begin
    cond   = ce & ~cs_n & ~rc;
    armed  = (cnt_q == WARM_V);
    prev_d = cond;
    cnt_d  = armed ? cnt_q : cnt_q + 1'b1;
    // The combined condition rises once, on whichever input is last.
    start_evt = armed & cond & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sbc_conv_fsm.sv
module sbc_conv_fsm #(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          a0_live,
  input  logic          sar_done,
  input  logic [DW-1:0] sar_result,
  output logic          busy,
  output logic          conv_start,
  output logic          conv_short,
  output logic          have_data,
  output logic [DW-1:0] result
);

  localparam int LW = DW - BW;
  localparam logic [LW-1:0] MARK = {1'b1, {(LW-1){1'b0}}};

  logic          busy_q, busy_d;
  logic          start_q, start_d;
  logic          a0_q, a0_d;
  logic          have_q, have_d;
  logic [DW-1:0] res_q, res_d;
  logic          res_en;

  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    a0_d    = a0_q;
    have_d  = have_q;
    res_en  = 1'b0;
    res_d   = res_q;

    // Any start edge re-captures the length, running or not.
    if (start_evt) a0_d = a0_live;

    if (start_evt && !busy_q) begin
      busy_d  = 1'b1;
      start_d = 1'b1;
    end

    // Completion wins over a coincident start: it uses the old length.
    if (busy_q && sar_done) begin
      busy_d = 1'b0;
      have_d = 1'b1;
      res_en = 1'b1;
      res_d  = a0_q ? {sar_result[DW-1:LW], MARK} : sar_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      a0_q    <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      a0_q    <= a0_d;
      have_q  <= have_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign busy       = busy_q;
  assign conv_start = start_q;
  assign conv_short = a0_q;
  assign have_data  = have_q;
  assign result     = res_q;

endmodule

// File: rtl/sbc_readout.sv
module sbc_readout
  import sar_bus_pkg::*;
#(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic          busy,
  input  logic          have_data,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] dbus,
  output logic [DW-1:0] dbus_oe
);

  localparam int LW = DW - BW;
  localparam logic [DW-1:0] BYTE_OE = {{BW{1'b1}}, {LW{1'b0}}};

  logic          rd_en;
  logic [DW-1:0] dat_q, dat_d;
  logic [DW-1:0] oe_q, oe_d;

  always_comb begin
    rd_en = ctl.rc & ctl.ce & ~ctl.cs_n & ~busy & have_data;
    dat_d = '0;
    oe_d  = '0;
    if (rd_en) begin
      if (ctl.word) begin
        oe_d  = '1;
        dat_d = result;
      end else if (ctl.a0) begin
        oe_d  = BYTE_OE;
        dat_d = {result[LW-1:0], {(DW-LW){1'b0}}};
      end else begin
        oe_d  = BYTE_OE;
        dat_d = {result[DW-1:LW], {LW{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      oe_q  <= '0;
    end else begin
      dat_q <= dat_d;
      oe_q  <= oe_d;
    end
  end

  assign dbus    = dat_q;
  assign dbus_oe = oe_q;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_in,
  input  logic              cs_n_in,
  input  logic              rc_in,
  input  logic              a0_in,
  input  logic              word_in,
  input  logic              sar_done,
  input  logic [DATA_W-1:0] sar_result,
  output logic              conv_start,
  output logic              conv_short,
  output logic              busy,
  output logic [DATA_W-1:0] dbus,
  output logic [DATA_W-1:0] dbus_oe
);

  ctl_t              ctl_raw;
  ctl_t              ctl_s;
  logic [CTL_W-1:0]  ctl_vec;
  logic              start_evt;
  logic              have_data;
  logic [DATA_W-1:0] result;

  always_comb begin
    ctl_raw.ce   = ce_in;
    ctl_raw.cs_n = cs_n_in;
    ctl_raw.rc   = rc_in;
    ctl_raw.a0   = a0_in;
    ctl_raw.word = word_in;
  end

  sbc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_vec)
  );

  assign ctl_s = ctl_t'(ctl_vec);

  sbc_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ctl_s.ce),
    .cs_n      (ctl_s.cs_n),
    .rc        (ctl_s.rc),
    .start_evt (start_evt)
  );

  sbc_conv_fsm #(.DW(DATA_W), .BW(BYTE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .a0_live    (ctl_s.a0),
    .sar_done   (sar_done),
    .sar_result (sar_result),
    .busy       (busy),
    .conv_start (conv_start),
    .conv_short (conv_short),
    .have_data  (have_data),
    .result     (result)
  );

  sbc_readout #(.DW(DATA_W), .BW(BYTE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl_s),
    .busy      (busy),
    .have_data (have_data),
    .result    (result),
    .dbus      (dbus),
    .dbus_oe   (dbus_oe)
  );

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          conv_start,
  input logic          sar_done,
  input logic [DW-1:0] dbus,
  input logic [DW-1:0] dbus_oe
);

  localparam logic [DW-1:0] BYTE_OE = {{BW{1'b1}}, {(DW-BW){1'b0}}};

  assert_busy_rise_has_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_start);

  assert_start_only_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy));

  assert_busy_ends_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sar_done));

  assert_bus_off_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dbus_oe == '0));

  assert_undriven_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus & ~dbus_oe) == '0);

  assert_enable_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe == '0) || (dbus_oe == '1) || (dbus_oe == BYTE_OE));

  assert_done_clears_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sar_done) |=> !busy);

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.DW(DATA_W), .BW(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .conv_start (conv_start),
  .sar_done   (sar_done),
  .dbus       (dbus),
  .dbus_oe    (dbus_oe)
);

// File: tb/sim_sar_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sar_bus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, cs_n, rc, a0, word;
  logic        sar_done;
  logic [11:0] sar_result;
  logic        conv_start, conv_short, busy;
  logic [11:0] dbus, dbus_oe;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  int s0     = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sar_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_in(ce), .cs_n_in(cs_n), .rc_in(rc),
    .a0_in(a0), .word_in(word), .sar_done(sar_done), .sar_result(sar_result),
    .conv_start(conv_start), .conv_short(conv_short), .busy(busy),
    .dbus(dbus), .dbus_oe(dbus_oe)
  );

  always @(posedge clk) if (rst_n && conv_start) starts <= starts + 1;

  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_conv(logic [11:0] v);
    sar_result = v;
    sar_done   = 1'b1;
    wn(1);
    sar_done   = 1'b0;
    wn(2);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] v, st, eo, ed;
    int idx;
    rst_n = 1'b0; ce = 1'b0; cs_n = 1'b1; rc = 1'b1; a0 = 1'b0; word = 1'b1;
    sar_done = 1'b0; sar_result = '0;
    wn(3);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 conv_start", conv_start, 0);
    chk("R11 conv_short", conv_short, 0);
    chk("R11 oe", dbus_oe, 0);
    chk("R11 dbus", dbus, 0);
    rst_n = 1'b1;
    wn(6);
    chk("R11 oe after release", dbus_oe, 0);

    // R5: read conditions met but nothing converted yet
    ce = 1'b1; cs_n = 1'b0; rc = 1'b1;
    wn(5);
    chk("R5 no data yet", dbus_oe, 0);

    // First conversion, then R4 re-start during busy
    s0 = starts;
    rc = 1'b0;
    wn(4);
    chk("R1 first start", starts - s0, 1);
    chk("R3 busy high", busy, 1);
    chk("R2 length 12", conv_short, 0);
    rc = 1'b1;
    wn(4);
    a0 = 1'b1; rc = 1'b0;
    wn(4);
    chk("R4 no second pulse", starts - s0, 1);
    chk("R4 still busy", busy, 1);
    chk("R4 relatched a0", conv_short, 1);
    rc = 1'b1;
    wn(4);
    chk("R5 busy blocks read", dbus_oe, 0);
    finish_conv(12'hA5C);
    chk("R3 busy low after done", busy, 0);
    word = 1'b1;
    wn(4);
    chk("R9 oe", dbus_oe, 12'hFFF);
    chk("R9 marker nibble", dbus, 12'hA58);

    // Sweep: trigger order x length x read format
    ce = 1'b0; cs_n = 1'b1;
    wn(4);
    idx = 0;
    for (int trig = 0; trig < 4; trig++) begin
      for (int sh = 0; sh < 2; sh++) begin
        for (int fmt = 0; fmt < 3; fmt++) begin
          v = 12'h9C3 ^ 12'(idx * 859);
          idx++;
          ce = 1'b0; cs_n = 1'b1; rc = 1'b1; word = 1'b1; a0 = sh[0];
          wn(4);
          s0 = starts;
          case (trig)
            0: begin cs_n = 1'b0; rc = 1'b0; wn(5); chk("R1 partial no ce", starts - s0, 0); ce = 1'b1; end
            1: begin ce = 1'b1; rc = 1'b0; wn(5); chk("R1 partial no cs", starts - s0, 0); cs_n = 1'b0; end
            2: begin ce = 1'b1; cs_n = 1'b0; wn(5); chk("R1 partial no rc", starts - s0, 0); rc = 1'b0; end
            default: begin ce = 1'b1; cs_n = 1'b0; rc = 1'b0; end
          endcase
          wn(4);
          chk("R1 one pulse", starts - s0, 1);
          chk("R3 busy", busy, 1);
          chk("R2 length", conv_short, 32'(sh));
          rc = 1'b1;
          wn(4);
          chk("R5 busy blocks read", dbus_oe, 0);
          finish_conv(v);
          chk("R3 done", busy, 0);
          st = (sh != 0) ? {v[11:4], 4'b1000} : v;
          word = (fmt == 0);
          a0 = (fmt == 2);
          wn(4);
          case (fmt)
            0:       begin eo = 12'hFFF; ed = st; end
            1:       begin eo = 12'hFF0; ed = {st[11:4], 4'h0}; end
            default: begin eo = 12'hFF0; ed = {st[3:0], 8'h00}; end
          endcase
          if (fmt == 0)      begin chk(sh ? "R9 word oe" : "R6 word oe", dbus_oe, eo); chk(sh ? "R9 word" : "R6 word", dbus, ed); end
          else if (fmt == 1) begin chk("R7 high oe", dbus_oe, eo); chk("R7 high byte", dbus, ed); end
          else               begin chk("R8 low oe", dbus_oe, eo); chk(sh ? "R9 low byte" : "R8 low byte", dbus, ed); end
          ce = 1'b0;
          wn(4);
          chk("R5 ce low off", dbus_oe, 0);
          cs_n = 1'b1;
        end
      end
    end

    // R12: start edge coinciding with completion
    a0 = 1'b0; word = 1'b1;
    ce = 1'b1; cs_n = 1'b0; rc = 1'b0;
    wn(4);
    chk("R12 setup busy", busy, 1);
    rc = 1'b1;
    wn(4);
    s0 = starts;
    rc = 1'b0; a0 = 1'b1;
    wn(2);
    sar_result = 12'h3C7;
    sar_done = 1'b1;
    wn(1);
    sar_done = 1'b0;
    wn(4);
    chk("R12 no new start", starts - s0, 0);
    chk("R12 busy cleared", busy, 0);
    chk("R4 relatch at collision", conv_short, 1);
    rc = 1'b1;
    wn(4);
    chk("R12 old length kept", dbus, 12'h3C7);

    // R13: start condition present across reset release
    ce = 1'b1; cs_n = 1'b0; rc = 1'b0; a0 = 1'b0; word = 1'b1;
    rst_n = 1'b0;
    wn(2);
    chk("R11 busy in reset", busy, 0);
    chk("R11 oe in reset", dbus_oe, 0);
    s0 = starts;
    rst_n = 1'b1;
    wn(8);
    chk("R13 no start after reset", starts - s0, 0);
    chk("R13 idle", busy, 0);

    // R10: stand-alone tie-off
    rc = 1'b1;
    wn(4);
    chk("R10 no data before conversion", dbus_oe, 0);
    s0 = starts;
    rc = 1'b0;
    wn(4);
    chk("R10 falling rc starts", starts - s0, 1);
    chk("R10 busy", busy, 1);
    rc = 1'b1;
    wn(4);
    chk("R10 no data while busy", dbus_oe, 0);
    finish_conv(12'h5E1);
    wn(2);
    chk("R10 oe", dbus_oe, 12'hFFF);
    chk("R10 data", dbus, 12'h5E1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule